// File: doc/BRIEF.md
# Serial SAR Converter Output Sequencer

This block models the digital serial output of a 16-bit sampling converter. A host drives an active-low select line and a data clock. The block takes a parallel two's complement result and puts it out one bit at a time on a serial line that can be tri-stated. The line is shown as a data bit plus an output enable. Both host signals are sampled by the block's own system clock, so the data clock must run well below the system clock. All sequencing happens on the data clock's falling edges as the system clock sees them.

After select falls, the block counts a sampling interval of five falling clock edges, with the line in high impedance. It then drives one low null bit. The result follows most significant bit first. Once bit 0 has been sent, the block replays bits 1 through 15 least significant bit first, so bit 0 serves both orders. It then tri-states and waits for select to go high. Raising select at any point ends the transfer at once, which lets a host stop after only the bits it needs. Two flags report which power domains may be idle.

Top module: `sar_serial_seq`

## Requirements
- R1: A cycle starts only when the system clock sees select go from high to low. If select is low when reset ends, or is held low after a cycle finishes, data clock edges start nothing.
- R2: From the start of a cycle, the output enable stays low through the first four data clock falling edges. It goes high after the fifth.
- R3: After the fifth falling edge, the data bit is 0 for one data clock period. This is the null bit.
- R4: The next 16 falling edges each present one result bit, from bit 15 down to bit 0. The bit changes only on a falling edge.
- R5: The 15 falling edges after bit 0 present bits 1, 2, … 15 in that order. The falling edge after bit 15 drops the output enable. Further falling edges leave it low until select has gone high.
- R6: The result input is captured on the fifth falling edge. Later changes to it do not alter the bits shifted out in that cycle.
- R7: While select is high, the output enable is low, with no clock edge needed. A later high-to-low transition of select starts a fresh cycle from R2.
- R8: `digital_pd` equals select being high. `analog_pd` is high while select is high, through the replay and the finished state, and while no cycle is running. It is low during sampling, the null bit and the MSB-first bits.
- R9: The codes 16'h7FFF, 16'h0000, 16'hFFFF and 16'h8000 come out bit-exact in both orders.
- R10: A synchronous active-low reset puts the block in the idle state. The output enable is then low and `analog_pd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Select from the host, active low |
| dclk | input | 1 | Data clock from the host, slower than clk |
| result | input | 16 | Parallel two's complement conversion result |
| sdo | output | 1 | Serial data bit |
| sdo_en | output | 1 | Output enable; low means high impedance |
| analog_pd | output | 1 | Analog section may be powered down |
| digital_pd | output | 1 | Digital section fully powered down |

## Verification
Assertions check the following on every cycle:
- the enable clears in the cycle after select goes high;
- the enable rises only after a detected falling edge, and always with a low bit;
- the data bit holds steady between falling edges;
- the finished state never drives the line.

Only the bench scenarios can show these:
- the exact bit order in both directions, for the boundary codes and for sweeps of walking-one and arithmetic patterns;
- that the result is captured at the end of sampling;
- the immediate abort and restart;
- that select held low after reset, or after a finished cycle, starts nothing.

// File: rtl/sar_serial_pkg.sv
// Package: shared types for the serial SAR output sequencer.
// Assumes: nothing; holds only the phase encoding used by the FSM and the output mux.
package sar_serial_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SAMPLE = 3'd1,
        PH_NULL   = 3'd2,
        PH_MSB    = 3'd3,
        PH_LSB    = 3'd4,
        PH_DONE   = 3'd5
    } phase_t;

endpackage

// File: rtl/sar_edge_sense.sv
// Module: falling-edge detector for N slow host signals, sampled by clk.
// Assumes: inputs are already synchronous to clk and each level lasts at least
// one clk period. RST_VAL sets the remembered level after reset, so a signal
// that is low at reset release is not seen as a falling edge.
module sar_edge_sense #(
    parameter int          N       = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig,
    output logic [N-1:0] fall
);

    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Remember the previous level of this input.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[i] <= RST_VAL[i];
            else        prev_q[i] <= sig[i];
        end
        // A fall is a high level followed by a low one.
        assign fall[i] = prev_q[i] & ~sig[i];
    end

endmodule

// File: rtl/sar_phase_fsm.sv
// Module: phase sequencer. It counts data clock falling edges through the
// sampling, null, MSB-first and LSB-replay phases.
// Assumes: cs_fall and dclk_fall are single-cycle strobes from sar_edge_sense.
// Select high overrides everything and returns the FSM to idle.
module sar_phase_fsm
    import sar_serial_pkg::*;
#(
    parameter int W            = 16,
    parameter int SAMPLE_FALLS = 5,
    localparam int CNT_MAX     = (W > SAMPLE_FALLS) ? W : SAMPLE_FALLS,
    localparam int CW          = $clog2(CNT_MAX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          cs_fall,
    input  logic          dclk_fall,
    output phase_t        phase,
    output logic [CW-1:0] cnt,
    output logic          capture
);

    localparam logic [CW-1:0] SAMPLE_LAST = CW'(SAMPLE_FALLS - 1);
    localparam logic [CW-1:0] MSB_LAST    = CW'(W - 1);
    localparam logic [CW-1:0] LSB_LAST    = CW'(W - 2);

    phase_t        phase_d;
    logic [CW-1:0] cnt_d;

    // Next phase and in-phase counter, advanced on data clock falls only.
    always_comb begin
        phase_d = phase;
        cnt_d   = cnt;
        if (cs_n) begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
        end else if (cs_fall) begin
            phase_d = PH_SAMPLE;
            cnt_d   = '0;
        end else if (dclk_fall) begin
            unique case (phase)
                PH_SAMPLE: begin
                    if (cnt == SAMPLE_LAST) begin
                        phase_d = PH_NULL;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt + 1'b1;
                    end
                end
                PH_NULL: begin
                    phase_d = PH_MSB;
                    cnt_d   = '0;
                end
                PH_MSB: begin
                    if (cnt == MSB_LAST) begin
                        phase_d = PH_LSB;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt + 1'b1;
                    end
                end
                PH_LSB: begin
                    if (cnt == LSB_LAST) begin
                        phase_d = PH_DONE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt + 1'b1;
                    end
                end
                default: begin
                    phase_d = phase;
                    cnt_d   = cnt;
                end
            endcase
        end
    end

    // Phase and counter registers with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            phase <= phase_d;
            cnt   <= cnt_d;
        end
    end

    // Capture strobe: the fall that ends the sampling interval.
    assign capture = ~cs_n & ~cs_fall & dclk_fall
                   & (phase == PH_SAMPLE) & (cnt == SAMPLE_LAST);

endmodule

// File: rtl/sar_word_hold.sv
// Module: holds the captured result and picks the bit the current phase and
// count call for: null, MSB-first, or the LSB-first replay starting at bit 1.
// Assumes: cnt stays below W-1 in the replay phase, as the FSM guarantees.
module sar_word_hold
    import sar_serial_pkg::*;
#(
    parameter int W  = 16,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [W-1:0]  result,
    input  phase_t        phase,
    input  logic [CW-1:0] cnt,
    output logic          bit_out
);

    logic [W-1:0] word_q;
    logic [W-1:0] msb_view;
    logic [W-1:0] lsb_view;

    // Capture the parallel result at the end of sampling.
    always_ff @(posedge clk) begin
        if (!rst_n)       word_q <= '0;
        else if (capture) word_q <= result;
    end

    // Shifted views: MSB-first reads the top bit, the replay reads bit 1.
    assign msb_view = word_q << cnt;
    assign lsb_view = word_q >> cnt;

    // Select the bit for the current phase.
    always_comb begin
        unique case (phase)
            PH_MSB:  bit_out = msb_view[W-1];
            PH_LSB:  bit_out = lsb_view[1];
            default: bit_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/sar_serial_seq.sv
// Module: top of the serial SAR output sequencer.
// Assumes: cs_n and dclk are synchronous to clk, and dclk's high and low
// times each last at least one clk. The output enable is gated directly by
// cs_n, so raising select tri-states the line without waiting for a clock.
module sar_serial_seq
    import sar_serial_pkg::*;
#(
    parameter int W            = 16,
    parameter int SAMPLE_FALLS = 5,
    localparam int CNT_MAX     = (W > SAMPLE_FALLS) ? W : SAMPLE_FALLS,
    localparam int CW          = $clog2(CNT_MAX)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         dclk,
    input  logic [W-1:0] result,
    output logic         sdo,
    output logic         sdo_en,
    output logic         analog_pd,
    output logic         digital_pd
);

    logic [1:0]    falls;
    logic          cs_fall;
    logic          dclk_fall;
    phase_t        phase;
    logic [CW-1:0] cnt;
    logic          capture;
    logic          bit_sel;
    logic          driving;

    sar_edge_sense #(.N(2), .RST_VAL(2'b00)) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   ({cs_n, dclk}),
        .fall  (falls)
    );
    assign cs_fall   = falls[1];
    assign dclk_fall = falls[0];

    sar_phase_fsm #(.W(W), .SAMPLE_FALLS(SAMPLE_FALLS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .cs_fall   (cs_fall),
        .dclk_fall (dclk_fall),
        .phase     (phase),
        .cnt       (cnt),
        .capture   (capture)
    );

    sar_word_hold #(.W(W), .CW(CW)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .result  (result),
        .phase   (phase),
        .cnt     (cnt),
        .bit_out (bit_sel)
    );

    // The line is driven in the null, MSB-first and replay phases.
    assign driving = (phase == PH_NULL) | (phase == PH_MSB) | (phase == PH_LSB);

    // Output and power flags; select high wins at once.
    assign sdo_en     = driving & ~cs_n;
    assign sdo        = bit_sel & sdo_en;
    assign digital_pd = cs_n;
    assign analog_pd  = cs_n | (phase == PH_LSB) | (phase == PH_DONE)
                      | (phase == PH_IDLE);

endmodule

// File: rtl/sar_serial_seq_checker.sv
// Module: assertion checker bound to sar_serial_seq. It watches the ports
// together with the edge strobes and the phase register.
// Assumes: bound through the bind statement at the end of this file.
module sar_serial_seq_checker
    import sar_serial_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   cs_n,
    input logic   sdo,
    input logic   sdo_en,
    input logic   analog_pd,
    input logic   digital_pd,
    input logic   cs_fall,
    input logic   dclk_fall,
    input phase_t phase
);

    // R7: select high clears the enable on the next cycle.
    assert_abort_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !sdo_en);

    // R2: the enable rises only after a detected data clock fall.
    assert_enable_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_en) |-> $past(dclk_fall));

    // R3: the first driven bit is the low null bit.
    assert_null_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_en) |-> (sdo == 1'b0));

    // R1: right after select falls, the line is still in the sampling interval.
    assert_start_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(digital_pd) |=> !sdo_en);

    // R5: the finished state never drives the line again.
    assert_done_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DONE) |=> !sdo_en);

    // R4: the data bit holds between falls while select stays low.
    assert_bit_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(dclk_fall) && !$past(cs_fall) && !cs_n && !$past(cs_n))
        |-> $stable(sdo));

    // R8: with select low, the analog flag rises only on a data clock fall.
    assert_analog_pd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(analog_pd) && !cs_n) |-> $past(dclk_fall));

endmodule

bind sar_serial_seq sar_serial_seq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .sdo        (sdo),
    .sdo_en     (sdo_en),
    .analog_pd  (analog_pd),
    .digital_pd (digital_pd),
    .cs_fall    (cs_fall),
    .dclk_fall  (dclk_fall),
    .phase      (phase)
);

// File: tb/sar_serial_seq_bench.sv
module sar_serial_seq_bench;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1;
    logic         dclk = 1'b0;
    logic [W-1:0] result = '0;
    logic         sdo, sdo_en, analog_pd, digital_pd;

    int checks = 0;
    int errors = 0;
    bit reported = 1'b0;

    always #10 clk = ~clk;

    sar_serial_seq #(.W(W), .SAMPLE_FALLS(5)) u_sar_serial_seq (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dclk(dclk), .result(result),
        .sdo(sdo), .sdo_en(sdo_en), .analog_pd(analog_pd), .digital_pd(digital_pd)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        end
    endtask

    // One data clock period: high half, then low half ending on a negedge.
    task automatic pulse();
        @(negedge clk) dclk = 1'b1;
        repeat (2) @(negedge clk);
        dclk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic select_low();
        @(negedge clk) cs_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic select_high();
        @(negedge clk) cs_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 digital_pd high", digital_pd, 1);
        check("R8 analog_pd high", analog_pd, 1);
        check("R7 enable low", sdo_en, 0);
    endtask

    // Full transfer of word; alt is put on the input after capture.
    task automatic transfer(logic [W-1:0] word, logic [W-1:0] alt);
        result = word;
        select_low();
        check("R8 digital_pd low", digital_pd, 0);
        check("R8 analog_pd low in sampling", analog_pd, 0);
        for (int i = 1; i <= 4; i++) begin
            pulse();
            check("R2 hi-Z during sampling", sdo_en, 0);
        end
        pulse();
        check("R2 enabled after fifth fall", sdo_en, 1);
        check("R3 null bit", sdo, 0);
        result = alt;
        for (int i = 0; i < W; i++) begin
            pulse();
            check("R4 MSB-first bit (R6 latched)", {sdo_en, sdo}, {1'b1, word[W-1-i]});
            check("R8 analog_pd low MSB", analog_pd, 0);
        end
        for (int i = 1; i < W; i++) begin
            pulse();
            check("R5 LSB replay bit", {sdo_en, sdo}, {1'b1, word[i]});
            check("R8 analog_pd high replay", analog_pd, 1);
        end
        pulse();
        check("R5 tri-state after replay", sdo_en, 0);
        for (int i = 0; i < 6; i++) begin
            pulse();
            check("R1 R5 no restart while low", sdo_en, 0);
        end
        check("R8 analog_pd after done", analog_pd, 1);
        select_high();
    endtask

    initial begin
        #3_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        // R10 reset with select held low (also R1: no start without a high).
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 enable low after reset", sdo_en, 0);
        check("R10 analog_pd after reset", analog_pd, 1);
        for (int i = 0; i < 8; i++) begin
            pulse();
            check("R1 no start after reset low", sdo_en, 0);
        end
        select_high();

        // R9 boundary codes.
        transfer(16'h7FFF, 16'h8000);
        transfer(16'h0000, 16'hFFFF);
        transfer(16'hFFFF, 16'h0000);
        transfer(16'h8000, 16'h7FFF);

        // Walking ones with inverted input after capture (R6).
        for (int k = 0; k < W; k++) begin
            logic [W-1:0] wv;
            wv = W'(1) << k;
            transfer(wv, ~wv);
        end
        // Arithmetic sweep.
        for (int k = 0; k < 12; k++) begin
            logic [W-1:0] wv;
            wv = W'(k * 40503 + 123);
            transfer(wv, wv ^ 16'hA5A5);
        end

        // R7 short cycle: abort in the middle of MSB-first bits.
        result = 16'hC3A5;
        select_low();
        for (int i = 0; i < 5 + 8; i++) pulse();
        check("R7 driving before abort", sdo_en, 1);
        @(negedge clk) cs_n = 1'b1;
        #2;
        check("R7 immediate tri-state", sdo_en, 0);
        check("R7 digital_pd immediate", digital_pd, 1);
        repeat (3) @(negedge clk);
        transfer(16'h1234, 16'h0F0F);

        report();
        $finish;
    end

endmodule